// File: doc/BRIEF.md
# Word-Write Sequencer for a Small Non-Volatile Memory

This controller sits between an asynchronous host and a 32-word by 16-bit non-volatile memory macro. Three host strobes (read, erase, program) are brought into the tag clock domain, and each rising edge starts a sequence. A program request always runs two timed high-voltage phases on the addressed word: an erase, then a program of the new data. An erase request runs the erase phase alone. Each high-voltage phase lasts a fixed number of clock cycles, 2304 by default, which gives 1.2 ms at a 1.92 MHz tag clock. That window leaves room for the charge pumps to ramp.

During a high-voltage phase the negative pump is enabled first. The positive pump is enabled only once a level-detect input reports that the negative rail has reached its target. A read runs three steps: it selects the row, then drives the control gate while the bit lines settle, then pulls the active-low sense enable low. The sensed word is latched onto the data output at the end of the sense step. The analog pumps, cell array and sense amplifiers lie outside this block; it sees them only as enable outputs, a level-detect input and a sensed-data input.

Top module: `nvm_word_seq`

## Requirements
- R1: While rst_ni is low, every output is in its idle state at once, including in the middle of a phase: busy, both mode enables, both pump enables, row select and control-gate enable are 0, sa_en_no is 1, and dout_o is 0.
- R2: A program request starts a write. The request is counted from the first clock edge at which pgm_i is sampled high. busy_o and erase_mode_o rise after the third such edge and stay high for PHASE_CYC cycles. prog_mode_o then stays high for PHASE_CYC cycles, and the controller returns to idle.
- R3: An erase request, detected with the same latency, runs only the erase phase of PHASE_CYC cycles and then returns to idle; prog_mode_o stays 0.
- R4: neg_pump_o is high in every erase or program cycle. pos_pump_o is 0 in the first cycle of each phase. It goes to 1 in the cycle after neg_ok_i is first sampled high within that phase, stays 1 until the phase ends, and is never 1 outside a phase.
- R5: busy_o is high from the first erase cycle to the last program cycle. Strobes that rise while the controller is busy or reading have no effect.
- R6: addr_i is captured when any request is accepted, and din_i is captured when a program or erase request is accepted. addr_o and wdata_o keep these values until the next accepted request, whatever happens on the inputs.
- R7: A read keeps row_sel_o high for ROW_CYC+CG_CYC+SENSE_CYC cycles. cg_en_o is high in the last CG_CYC+SENSE_CYC of those cycles, and sa_en_no is low in the last SENSE_CYC of them. At the end, dout_o takes sa_data_i and holds it until the next read or reset.
- R8: When rising edges are detected in the same cycle, the program request wins over erase, and erase wins over read. The losing requests are dropped.
- R9: A request starts only on a rising edge. A strobe held high after its sequence ends does not start it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tag clock |
| rst_ni | input | 1 | Asynchronous active-low reset and abort |
| rd_i | input | 1 | Read strobe (asynchronous) |
| ers_i | input | 1 | Erase-only strobe (asynchronous) |
| pgm_i | input | 1 | Write strobe: erase then program (asynchronous) |
| addr_i | input | 5 | Word address |
| din_i | input | 16 | Word to be written |
| neg_ok_i | input | 1 | Negative rail has reached its target |
| sa_data_i | input | 16 | Word from the sense amplifiers |
| busy_o | output | 1 | High-voltage phase in progress |
| erase_mode_o | output | 1 | Drivers in erase bias |
| prog_mode_o | output | 1 | Drivers in program bias |
| neg_pump_o | output | 1 | Negative pump enable |
| pos_pump_o | output | 1 | Positive pump enable |
| row_sel_o | output | 1 | Row select for read |
| cg_en_o | output | 1 | Control gate raised for read |
| sa_en_no | output | 1 | Active-low sense-amplifier enable |
| addr_o | output | 5 | Captured word address |
| wdata_o | output | 16 | Captured write word |
| dout_o | output | 16 | Last word read |

## Verification
Two kinds of collision matter here. A read strobe can rise in the same synchronized cycle as a program strobe. A read or erase strobe can also rise while a write is still running, which is the point where start decoding and the busy interval meet. The bench drives rd_i and pgm_i up in the same cycle and expects a write with no read steps. It also pulses rd_i, ers_i, addr_i and din_i in the middle of a write and expects the phase timing and the captured address and data to stay the same. Every cycle, a behavioural reference model predicts all outputs and each one is compared against it.

// File: rtl/nvm_seq_pkg.sv
`timescale 1ns/1ps
package nvm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_PROG  = 3'd2,
    ST_ROW   = 3'd3,
    ST_CG    = 3'd4,
    ST_SENSE = 3'd5
  } seq_state_e;

  // strobe vector positions
  localparam int unsigned STB_RD  = 0;
  localparam int unsigned STB_ERS = 1;
  localparam int unsigned STB_PGM = 2;
  localparam int unsigned STB_N   = 3;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_edge_sync.sv
`timescale 1ns/1ps
module nvm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/nvm_phase_timer.sv
`timescale 1ns/1ps
module nvm_phase_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done_o = en_i && (cnt_q == (limit_i - CNT_W'(1)));

  // R2
  cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/nvm_word_seq.sv
`timescale 1ns/1ps
module nvm_word_seq
  import nvm_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PHASE_CYC   = 2304,
  parameter int unsigned ROW_CYC     = 1,
  parameter int unsigned CG_CYC      = 2,
  parameter int unsigned SENSE_CYC   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              ers_i,
  input  logic              pgm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              neg_ok_i,
  input  logic [DATA_W-1:0] sa_data_i,
  output logic              busy_o,
  output logic              erase_mode_o,
  output logic              prog_mode_o,
  output logic              neg_pump_o,
  output logic              pos_pump_o,
  output logic              row_sel_o,
  output logic              cg_en_o,
  output logic              sa_en_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] dout_o
);

  localparam int unsigned RD_MAX  = max2(ROW_CYC, max2(CG_CYC, SENSE_CYC));
  localparam int unsigned LIM_MAX = max2(PHASE_CYC, RD_MAX);
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

  logic [STB_N-1:0] strb, rise;
  assign strb = {pgm_i, ers_i, rd_i};

  for (genvar g = 0; g < STB_N; g++) begin : g_sync
    nvm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (strb[g]),
      .rise_o (rise[g])
    );
  end

  seq_state_e       state_q, state_d;
  logic             prog_q, pos_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q, dout_q;
  logic             hv, done, accept;
  logic [CNT_W-1:0] limit;

  assign hv     = (state_q == ST_ERASE) || (state_q == ST_PROG);
  assign accept = (state_q == ST_IDLE) && (|rise);

  always_comb begin
    unique case (state_q)
      ST_ROW:   limit = CNT_W'(ROW_CYC);
      ST_CG:    limit = CNT_W'(CG_CYC);
      ST_SENSE: limit = CNT_W'(SENSE_CYC);
      default:  limit = CNT_W'(PHASE_CYC);
    endcase
  end

  nvm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (state_q != ST_IDLE),
    .clr_i   (done || (state_q == ST_IDLE)),
    .limit_i (limit),
    .done_o  (done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if      (rise[STB_PGM]) state_d = ST_ERASE;
        else if (rise[STB_ERS]) state_d = ST_ERASE;
        else if (rise[STB_RD])  state_d = ST_ROW;
      end
      ST_ERASE: if (done) state_d = prog_q ? ST_PROG : ST_IDLE;
      ST_PROG:  if (done) state_d = ST_IDLE;
      ST_ROW:   if (done) state_d = ST_CG;
      ST_CG:    if (done) state_d = ST_SENSE;
      ST_SENSE: if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      prog_q  <= 1'b0;
      pos_q   <= 1'b0;
      addr_q  <= '0;
      din_q   <= '0;
      dout_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) pos_q <= 1'b0;
      else if (hv)            pos_q <= pos_q | neg_ok_i;
      if (accept) begin
        addr_q <= addr_i;
        prog_q <= rise[STB_PGM];
        if (rise[STB_PGM] || rise[STB_ERS]) din_q <= din_i;
      end
      if ((state_q == ST_SENSE) && done) dout_q <= sa_data_i;
    end
  end

  assign busy_o       = hv;
  assign erase_mode_o = (state_q == ST_ERASE);
  assign prog_mode_o  = (state_q == ST_PROG);
  assign neg_pump_o   = hv;
  assign pos_pump_o   = pos_q;
  assign row_sel_o    = (state_q == ST_ROW) || (state_q == ST_CG) || (state_q == ST_SENSE);
  assign cg_en_o      = (state_q == ST_CG) || (state_q == ST_SENSE);
  assign sa_en_no     = (state_q != ST_SENSE);
  assign addr_o       = addr_q;
  assign wdata_o      = din_q;
  assign dout_o       = dout_q;

  // R4
  pos_needs_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_pump_o |-> neg_pump_o);

  // R4
  pos_after_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_pump_o) |-> $past(neg_ok_i));

  // R2
  prog_follows_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_mode_o) |-> $past(erase_mode_o));

  // R6
  addr_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(wdata_o)));

  // R7
  sense_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sa_en_no |-> (cg_en_o && row_sel_o));

  // R5
  no_read_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!row_sel_o && sa_en_no));

endmodule

// File: tb/nvm_word_seq_test.sv
`timescale 1ns/1ps
module nvm_word_seq_test;

  localparam int PH  = 2304;
  localparam int ROW = 1;
  localparam int CG  = 2;
  localparam int SEN = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, ers = 1'b0, pgm = 1'b0, neg_ok = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] din = '0, sa_data = '0;
  logic busy, er_m, pg_m, negp, posp, row, cg, sa_n;
  logic [4:0]  addr_o;
  logic [15:0] wdata, dout;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nvm_word_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .ers_i(ers), .pgm_i(pgm),
    .addr_i(addr), .din_i(din), .neg_ok_i(neg_ok), .sa_data_i(sa_data),
    .busy_o(busy), .erase_mode_o(er_m), .prog_mode_o(pg_m),
    .neg_pump_o(negp), .pos_pump_o(posp), .row_sel_o(row), .cg_en_o(cg),
    .sa_en_no(sa_n), .addr_o(addr_o), .wdata_o(wdata), .dout_o(dout)
  );

  // reference model: 0 idle, 1 erase, 2 program, 3 row, 4 gate, 5 sense
  int m_st, m_cnt;
  bit m_pos, m_prog;
  logic [4:0]  m_addr;
  logic [15:0] m_din, m_dout;
  logic [2:0]  s1, s2, s3;   // bit0 rd, bit1 ers, bit2 pgm

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_pos = 0; m_prog = 0;
    m_addr = '0; m_din = '0; m_dout = '0;
    s1 = '0; s2 = '0; s3 = '0;
  endtask

  initial m_reset();

  always @(negedge rst_n) m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [2:0] r;
      int lim;
      r = s2 & ~s3;
      lim = (m_st == 3) ? ROW : (m_st == 4) ? CG : (m_st == 5) ? SEN : PH;
      if (m_st == 0) begin
        if (r != 0) begin
          m_addr = addr;
          m_prog = r[2];
          if (r[2] || r[1]) m_din = din;
          m_st = (r[2] || r[1]) ? 1 : 3;
          m_cnt = 0;
        end
      end else if (m_cnt == lim - 1) begin
        if (m_st == 5) m_dout = sa_data;
        case (m_st)
          1: m_st = m_prog ? 2 : 0;
          2: m_st = 0;
          3: m_st = 4;
          4: m_st = 5;
          default: m_st = 0;
        endcase
        m_cnt = 0;
        m_pos = 0;
      end else begin
        m_cnt++;
        if (m_st == 1 || m_st == 2) m_pos = m_pos | neg_ok;
      end
      s3 = s2; s2 = s1; s1 = {pgm, ers, rd};
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      bit hv;
      hv = (m_st == 1 || m_st == 2);
      check("R5", "busy", busy, hv);
      check("R2", "erase_mode", er_m, m_st == 1);
      check("R2", "prog_mode", pg_m, m_st == 2);
      check("R4", "neg_pump", negp, hv);
      check("R4", "pos_pump", posp, m_pos);
      check("R7", "row_sel", row, m_st >= 3);
      check("R7", "cg_en", cg, m_st == 4 || m_st == 5);
      check("R7", "sa_en_n", sa_n, m_st != 5);
      check("R6", "addr_o", addr_o, m_addr);
      check("R6", "wdata", wdata, m_din);
      check("R7", "dout", dout, m_dout);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    cyc(3);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset sa_en_n", sa_n, 1);
    check("R1", "reset dout", dout, 0);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    cyc(3);

    // write with inputs disturbed mid-phase
    addr = 5'd3; din = 16'hA5A5; neg_ok = 1'b0; pgm = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    check("R2", "busy before third edge", busy, 0);
    @(posedge clk); #2;
    check("R2", "busy after third edge", busy, 1);
    cyc(1);
    pgm = 1'b0;
    cyc(40);
    addr = 5'd9; din = 16'hFFFF; rd = 1'b1; ers = 1'b1;
    cyc(4);
    rd = 1'b0; ers = 1'b0;
    cyc(60);
    neg_ok = 1'b1;
    cyc(2 * PH);
    check("R5", "write done", busy, 0);
    cyc(10);

    // erase only
    neg_ok = 1'b0; addr = 5'd7; din = 16'h1357; ers = 1'b1;
    cyc(4);
    ers = 1'b0;
    cyc(20);
    neg_ok = 1'b1;
    cyc(PH);
    check("R3", "erase-only finished", busy, 0);
    check("R3", "no program", pg_m, 0);
    cyc(10);

    // read with strobe held high
    addr = 5'd12; sa_data = 16'h1234; rd = 1'b1;
    cyc(25);
    check("R9", "held strobe row_sel", row, 0);
    check("R7", "read data", dout, 16'h1234);
    sa_data = 16'h4321;
    cyc(5);
    rd = 1'b0;
    cyc(10);

    // read and program together
    addr = 5'd20; din = 16'h0F0F; rd = 1'b1; pgm = 1'b1;
    cyc(4);
    check("R8", "program wins busy", busy, 1);
    check("R8", "no read row_sel", row, 0);
    rd = 1'b0; pgm = 1'b0;
    cyc(2 * PH + 10);
    check("R8", "dout unchanged", dout, 16'h1234);

    // abort mid erase
    addr = 5'd1; din = 16'h00FF; pgm = 1'b1;
    cyc(4);
    pgm = 1'b0;
    cyc(100);
    rst_n = 1'b0;
    #1;
    check("R1", "abort busy", busy, 0);
    check("R1", "abort neg_pump", negp, 0);
    check("R1", "abort pos_pump", posp, 0);
    check("R1", "abort dout", dout, 0);
    cyc(3);
    rst_n = 1'b1;
    cyc(10);
    check("R1", "idle after abort", busy, 0);

    cmp_en = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule